// File: doc/BRIEF.md
# Ethernet MAC Interrupt Register Block

This block collects event and condition signals from the receive path, the transmit path, the buffer allocator and the PHY-status logic of a packet-buffer Ethernet controller. It shows them to the host as an 8-bit status byte and combines them with an 8-bit enable byte to drive one active-high interrupt line.

The status bits come in two kinds. Four of them latch one-cycle event pulses and hold them until the host clears them. The host clears a bit by writing a 1 to the acknowledge register, which is write-only and sits at the same offset as the status register. The other four bits follow live conditions and cannot be acknowledged. One of these live bits reports that the transmit state machine is idle. It reads 1 while the transmitter is disabled, even if transmit packets are still queued.

The host reaches the block over a simple synchronous bus. One word holds status/acknowledge in the low byte and the enable (mask) byte in the high byte. Each byte has its own byte enable.

Top module: `eth_irq_regs`

## Requirements
- R1: `bus_rdata[7:0]` returns the status byte and `bus_rdata[15:8]` returns the mask byte. A read costs no cycle, and a write does not change the status value that reads return.
- R2: The latched bits are bit1 (transmit complete, `txc_pulse`), bit2 (transmit empty, `txe_pulse`), bit4 (receive overrun, `ovrn_pulse`) and bit6 (early receive, `erx_pulse`). Each one reads 1 from the clock after its pulse and holds until acknowledged.
- R3: A write with `bus_be[0]=1` clears each latched bit whose position holds a 1 in `bus_wdata[7:0]`. A 0 at that position leaves the bit unchanged. A 1 at bit 0, 3, 5 or 7 has no effect.
- R4: If an event pulse and an acknowledge of the same bit arrive in the same cycle, the bit stays 1.
- R5: Bit0 (`rx_lvl`), bit3 (`alloc_lvl`) and bit5 (`phy_lvl`) equal their inputs in the same cycle. They are never latched.
- R6: Bit7 equals the inverse of `tx_busy` in the same cycle, whatever else the block holds.
- R7: The mask resets to 0x00. A write with `bus_be[1]=1` loads `bus_wdata[15:8]` into it from the next clock. With `bus_be[1]=0` the mask is unchanged.
- R8: A write with `bus_be[0]=0` acknowledges nothing, whatever the low data byte holds.
- R9: `irq` is 1 exactly one clock after a cycle in which (status AND mask) is non-zero.
- R10: During reset and in the first cycle after it, the latched bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte enables: [0] acknowledge byte, [1] mask byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | {mask, status} |
| rx_lvl | input | 1 | Receive condition level |
| txc_pulse | input | 1 | Transmit complete pulse |
| txe_pulse | input | 1 | Transmit empty pulse |
| alloc_lvl | input | 1 | Allocation done level |
| ovrn_pulse | input | 1 | Receive overrun pulse |
| phy_lvl | input | 1 | PHY status level |
| erx_pulse | input | 1 | Early receive pulse |
| tx_busy | input | 1 | Transmit state machine active |
| irq | output | 1 | Interrupt request, active high |

## Verification
A latched bit that is lost, stuck or wrongly cleared shows in `bus_rdata[7:0]` on the very next sample after the clock edge that corrupted it. Because that bit also feeds `irq`, `irq` goes wrong one clock later whenever the bit is enabled. A corrupted mask shows in `bus_rdata[15:8]` right away and in `irq` one clock after that. A wrong live bit shows in the same cycle as its input. The reference model is compared every clock, so each fault is reported within one or two cycles of its cause, and directed phases cover collisions, byte-enable masking and writes to non-acknowledgeable positions.

// File: rtl/eth_irq_pkg.sv
// Package: shared bit positions and width for the interrupt register block.
// Assumes one byte of status and one byte of mask in a 16-bit bus word.
package eth_irq_pkg;
    localparam int STAT_W   = 8;
    localparam int BUS_W    = 2 * STAT_W;
    localparam int B_RX     = 0;
    localparam int B_TXC    = 1;
    localparam int B_TXE    = 2;
    localparam int B_ALLOC  = 3;
    localparam int B_OVRN   = 4;
    localparam int B_PHY    = 5;
    localparam int B_ERX    = 6;
    localparam int B_IDLE   = 7;
    // Positions holding latched (acknowledgeable) events.
    localparam logic [STAT_W-1:0] LATCHED_BITS = 8'b0101_0110;
endpackage

// File: rtl/irq_status_bank.sv
// Module: per-bit status storage. Each bit that LATCH_MASK marks is a set-dominant
// sticky flag cleared by acknowledge; every other bit passes its source straight through.
// Assumes event inputs are synchronous to clk; acknowledge is a one-cycle write strobe.
module irq_status_bank #(
    parameter int                W          = 8,
    parameter logic [W-1:0]      LATCH_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         ack_we,
    input  logic [W-1:0] ack_data,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LATCH_MASK[i]) begin : g_sticky
            logic flag_q;
            // Set on event, clear on acknowledge; the event wins a collision.
            always_ff @(posedge clk) begin
                if (!rst_n)                      flag_q <= 1'b0;
                else if (src[i])                 flag_q <= 1'b1;
                else if (ack_we && ack_data[i])  flag_q <= 1'b0;
            end
            assign stat[i] = flag_q;

            assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                src[i] |=> stat[i]);
            assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (src[i] && ack_we && ack_data[i]) |=> stat[i]);
            assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_we && ack_data[i] && !src[i]) |=> !stat[i]);
            assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!src[i] && !(ack_we && ack_data[i])) |=> stat[i] == $past(stat[i]));
        end else begin : g_live
            // Live condition: status mirrors the source.
            assign stat[i] = src[i];
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt enable byte, cleared at reset and written as one byte.
// Assumes wr_en is already qualified by select, write and the byte enable.
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask
);
    logic [W-1:0] mask_q;

    // Load the enable byte on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end
    assign mask = mask_q;

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mask == $past(wr_data));
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask));
endmodule

// File: rtl/irq_combine.sv
// Module: reduces enabled status to one registered interrupt line.
// Assumes the line may lag its cause by exactly one clock.
module irq_combine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] mask,
    output logic         irq
);
    logic irq_q;

    // Register the OR of enabled status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat & mask);
    end
    assign irq = irq_q;

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & mask)) |=> irq);
    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & mask)) |=> !irq);
endmodule

// File: rtl/eth_irq_regs.sv
// Module: top of the interrupt register block. Decodes bus writes into acknowledge
// (low byte) and mask load (high byte), gathers the event sources, returns {mask, status}.
// Assumes one register word; reads have no side effects.
module eth_irq_regs
    import eth_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_be,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rx_lvl,
    input  logic             txc_pulse,
    input  logic             txe_pulse,
    input  logic             alloc_lvl,
    input  logic             ovrn_pulse,
    input  logic             phy_lvl,
    input  logic             erx_pulse,
    input  logic             tx_busy,
    output logic             irq
);
    logic [STAT_W-1:0] src, stat, mask;
    logic              ack_we, mask_we;

    // Gather sources into their status positions.
    always_comb begin
        src          = '0;
        src[B_RX]    = rx_lvl;
        src[B_TXC]   = txc_pulse;
        src[B_TXE]   = txe_pulse;
        src[B_ALLOC] = alloc_lvl;
        src[B_OVRN]  = ovrn_pulse;
        src[B_PHY]   = phy_lvl;
        src[B_ERX]   = erx_pulse;
        src[B_IDLE]  = ~tx_busy;
    end

    assign ack_we  = bus_sel && bus_wr && bus_be[0];
    assign mask_we = bus_sel && bus_wr && bus_be[1];

    irq_status_bank #(.W(STAT_W), .LATCH_MASK(LATCHED_BITS)) u_stat (
        .clk(clk), .rst_n(rst_n), .src(src), .ack_we(ack_we),
        .ack_data(bus_wdata[STAT_W-1:0]), .stat(stat));

    irq_mask_reg #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_we),
        .wr_data(bus_wdata[BUS_W-1:STAT_W]), .mask(mask));

    irq_combine #(.W(STAT_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .stat(stat), .mask(mask), .irq(irq));

    assign bus_rdata = {mask, stat};

    assert_idle_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> bus_rdata[B_IDLE]);
    assert_byte_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_be[0] && !(|(stat & LATCHED_BITS)) == 1'b0)
        |=> ((stat & LATCHED_BITS) & $past(stat & LATCHED_BITS)) == $past(stat & LATCHED_BITS));
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!irq && ((bus_rdata[STAT_W-1:0] & LATCHED_BITS) == '0)));
endmodule

// File: tb/sim_eth_irq_regs.sv
// Bench: behavioural reference model, compared every clock at negedge + 1 ns.
module sim_eth_irq_regs;
    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_be = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic rx_lvl = 0, txc_pulse = 0, txe_pulse = 0, alloc_lvl = 0;
    logic ovrn_pulse = 0, phy_lvl = 0, erx_pulse = 0, tx_busy = 1;
    logic irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string phase = "R2";
    bit done = 0;

    // Reference state.
    bit [7:0] m_lat = 0, m_mask = 0;
    bit       m_irq = 0;
    localparam bit [7:0] LB = 8'b0101_0110;

    always #4 clk = ~clk;

    eth_irq_regs u0 (.*);

    function automatic bit [7:0] m_stat();
        bit [7:0] s;
        s = m_lat & LB;
        s[0] = rx_lvl; s[3] = alloc_lvl; s[5] = phy_lvl; s[7] = ~tx_busy;
        return s;
    endfunction

    // Reference update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_mask = 0; m_irq = 0;
        end else begin
            bit [7:0] ev;
            m_irq = |(m_stat() & m_mask);
            ev = {1'b0, erx_pulse, 1'b0, ovrn_pulse, 1'b0, txe_pulse, txc_pulse, 1'b0};
            if (bus_sel && bus_wr && bus_be[0]) m_lat = m_lat & ~bus_wdata[7:0];
            m_lat = (m_lat | ev) & LB;
            if (bus_sel && bus_wr && bus_be[1]) m_mask = bus_wdata[15:8];
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare all fields every cycle; R1 fixes status low, mask high.
    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            bit [7:0] s;
            s = m_stat();
            chk(phase, {8'h0, bus_rdata[7:0] & LB}, {8'h0, s & LB});
            chk("R5", {8'h0, bus_rdata[7:0] & 8'h29}, {8'h0, s & 8'h29});
            chk("R6", {15'h0, bus_rdata[7]}, {15'h0, s[7]});
            chk("R7", {8'h0, bus_rdata[15:8]}, {8'h0, m_mask});
            chk("R9", {15'h0, irq}, {15'h0, m_irq});
        end
    end

    task automatic idle_cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] be, logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic pulses(logic [7:0] p);
        txc_pulse = p[1]; txe_pulse = p[2]; ovrn_pulse = p[4]; erx_pulse = p[6];
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R10: reset state while in reset.
        chk("R10", {8'h0, irq, 7'h0} | {8'h0, bus_rdata[7:0] & LB}, 16'h0);
        rst_n = 1;
        @(negedge clk);
        #2 chk("R10", {15'h0, irq}, 16'h0);
        chk("R7", {8'h0, bus_rdata[15:8]}, 16'h0);

        // R2: each latched bit set by its pulse, held.
        phase = "R2";
        foreach (LB[b]) if (LB[b]) begin
            pulses(8'(1 << b)); @(negedge clk); pulses(0); idle_cyc(2);
        end
        // R3: acknowledge some, including non-ackable positions.
        phase = "R3";
        wr(2'b01, 16'h00A9); idle_cyc(1);
        wr(2'b01, 16'h0012); idle_cyc(1);
        wr(2'b01, 16'h0044); idle_cyc(1);
        // R4: collision of pulse and acknowledge.
        phase = "R4";
        pulses(8'h56); bus_sel = 1; bus_wr = 1; bus_be = 2'b01; bus_wdata = 16'h0056;
        @(negedge clk); pulses(0); bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
        idle_cyc(2);
        // R8: low byte disabled, acknowledge ignored; mask loaded.
        phase = "R8";
        wr(2'b10, 16'hFFFF); idle_cyc(2);
        wr(2'b10, 16'h00FF); idle_cyc(2);
        // R7/R9: mask variants against live bits.
        phase = "R9";
        wr(2'b10, 16'h8000); tx_busy = 0; idle_cyc(2); tx_busy = 1; idle_cyc(2);
        wr(2'b10, 16'h2900); phy_lvl = 1; idle_cyc(2); phy_lvl = 0; rx_lvl = 1; idle_cyc(2);
        rx_lvl = 0; alloc_lvl = 1; idle_cyc(1); alloc_lvl = 0; idle_cyc(2);
        wr(2'b11, 16'h56FF); idle_cyc(2);
        // Random mix.
        phase = "R2";
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] r;
            r = $urandom;
            {rx_lvl, alloc_lvl, phy_lvl, tx_busy} = r[3:0];
            pulses(r[3] ? r[11:4] : 8'h0);
            bus_sel = r[12]; bus_wr = r[13]; bus_be = r[15:14]; bus_wdata = r[31:16];
            @(negedge clk);
        end
        pulses(0); bus_sel = 0; bus_wr = 0;
        idle_cyc(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule